// File: doc/BRIEF.md
# Polled Character Terminal Peripheral

This block is a bus slave that makes a character terminal visible to a processor as four 32-bit registers in a small window at the top of the address space. The input half takes bytes from a keyboard-side stream and holds the latest one until software reads it. The output half takes one character from a processor store and offers it on a display-side stream with a valid/ready handshake.

Each half has a control register. Its flag bit tells software whether a character is waiting or whether a new one may be sent. Data-register accesses change these flags as a side effect, so software needs only a polling loop: test the flag, then touch the data register. An interrupt-enable bit in each control register lets the same flags drive a single interrupt line.

The bus is word addressed and has no wait states. Read data is combinational in the cycle of the access. Writes and read side effects take effect at the next clock edge.

Top module: `term_mmio`

## Requirements
- R1: After reset the input flag is 0, the output flag is 1, both enable bits are 0, `dsp_valid` is 0 and `irq` is 0.
- R2: The window starts at BASE (default 0xFFFF0000). Address bits [3:2] select the register: 0 is input control, 1 is input data, 2 is output control, 3 is output data. An access whose upper address bits [31:4] do not match BASE returns 0 and changes nothing.
- R3: A control register reads with bit 0 as its flag, bit 1 as its enable bit, and bits 31:2 as zero. The input data register returns the held character in bits 7:0 and zero above. The output data register reads as zero.
- R4: A keyboard byte (`kb_valid` high at a clock edge) is stored and sets the input flag. A byte that arrives while the flag is already 1 replaces the held character, and the flag stays 1.
- R5: A read of the input data register clears the input flag at the next edge. If a keyboard byte arrives in that same cycle, the arrival wins: the flag stays 1 and the new byte is held.
- R6: A write to either control register loads that register's enable bit from write bit 1. Write bit 0 has no effect on the flag.
- R7: A write to the output data register while the output flag is 1 places write bits 7:0 on `dsp_data`, raises `dsp_valid` and clears the flag at the next edge.
- R8: While `dsp_valid` is 1 and `dsp_ready` is 0, `dsp_valid` stays 1 and `dsp_data` holds its value.
- R9: The output flag returns to 1 only after two conditions are met: the display side has accepted the byte, and at least MIN_BUSY cycles have passed since the write. With `dsp_ready` held high and MIN_BUSY = 4, the flag reads 0 for exactly 4 cycles.
- R10: A write to the output data register while the output flag is 0 is ignored. The pending byte, `dsp_valid` and the busy time are left unchanged.
- R11: `irq` is 1 exactly when (input flag AND input enable) OR (output flag AND output enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| kb_valid | input | 1 | Keyboard byte present this cycle |
| kb_data | input | 8 | Keyboard byte |
| dsp_valid | output | 1 | Display byte offered |
| dsp_data | output | 8 | Display byte |
| dsp_ready | input | 1 | Display side takes the byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `kb_valid` and the bus strobes are at known values in every cycle after reset. They also assume the display side follows the valid/ready rule, meaning a transfer happens only on a cycle where both are high. The stimulus changes every input on the falling clock edge and keeps each bus access to exactly one cycle. A keyboard arrival is made to coincide with a data read only in the collision scenario, where that overlap is the point of the test. Display stalls are produced by holding `dsp_ready` low for a fixed count of cycles, then releasing it.

// File: rtl/term_pkg.sv
package term_pkg;
  localparam int CHAR_W  = 8;
  localparam int FLAG_B  = 0;
  localparam int EN_B    = 1;

  typedef enum logic [1:0] {
    SEL_IN_CTL  = 2'd0,
    SEL_IN_DAT  = 2'd1,
    SEL_OUT_CTL = 2'd2,
    SEL_OUT_DAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/term_decode.sv
module term_decode
  import term_pkg::*;
#(
  parameter int          ADDR_W = 32,
  parameter logic [31:0] BASE   = 32'hFFFF0000
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output reg_sel_e          which,
  output logic              rd_in_dat,
  output logic              wr_in_ctl,
  output logic              wr_out_ctl,
  output logic              wr_out_dat
);
  localparam logic [ADDR_W-5:0] BASE_HI = BASE[ADDR_W-1:4];

  always_comb begin
    hit        = sel && (addr[ADDR_W-1:4] == BASE_HI);
    which      = reg_sel_e'(addr[3:2]);
    rd_in_dat  = hit && !we && (which == SEL_IN_DAT);
    wr_in_ctl  = hit &&  we && (which == SEL_IN_CTL);
    wr_out_ctl = hit &&  we && (which == SEL_OUT_CTL);
    wr_out_dat = hit &&  we && (which == SEL_OUT_DAT);
  end
endmodule

// File: rtl/term_rx.sv
module term_rx
  import term_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kb_valid,
  input  logic [CHAR_W-1:0] kb_data,
  input  logic              rd_dat,
  input  logic              wr_ctl,
  input  logic              en_wbit,
  output logic              flag,
  output logic              en,
  output logic [CHAR_W-1:0] held
);
  logic              flag_d, en_d, held_ld;

  always_comb begin
    flag_d  = flag;
    held_ld = 1'b0;
    if (rd_dat) flag_d = 1'b0;
    if (kb_valid) begin
      flag_d  = 1'b1;
      held_ld = 1'b1;
    end
    en_d = wr_ctl ? en_wbit : en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      en   <= 1'b0;
      held <= '0;
    end else begin
      flag <= flag_d;
      en   <= en_d;
      if (held_ld) held <= kb_data;
    end
  end

  a_r4_arrival_sets: assert property (@(posedge clk) disable iff (!rst_n)
    kb_valid |=> (flag && held == $past(kb_data)));
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dat && !kb_valid) |=> !flag);
  a_r6_flag_untouched_by_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !kb_valid && !rd_dat) |=> $stable(flag));
endmodule

// File: rtl/term_tx.sv
module term_tx
  import term_pkg::*;
#(
  parameter int MIN_BUSY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_dat,
  input  logic [CHAR_W-1:0] wbyte,
  input  logic              wr_ctl,
  input  logic              en_wbit,
  input  logic              dsp_ready,
  output logic              flag,
  output logic              en,
  output logic              dsp_valid,
  output logic [CHAR_W-1:0] dsp_data
);
  localparam int CNT_W = $clog2(MIN_BUSY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MIN_BUSY);

  logic [CNT_W-1:0] cnt, cnt_d;
  logic             pend_d, en_d, accept;

  always_comb begin
    flag   = !dsp_valid && (cnt == '0);
    accept = wr_dat && flag;
    pend_d = dsp_valid;
    cnt_d  = cnt;
    if (cnt != '0) cnt_d = cnt - 1'b1;
    if (dsp_valid && dsp_ready) pend_d = 1'b0;
    if (accept) begin
      pend_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end
    en_d = wr_ctl ? en_wbit : en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsp_valid <= 1'b0;
      cnt       <= '0;
      en        <= 1'b0;
      dsp_data  <= '0;
    end else begin
      dsp_valid <= pend_d;
      cnt       <= cnt_d;
      en        <= en_d;
      if (accept) dsp_data <= wbyte;
    end
  end

  // checker: length of the current low stretch of the flag
  logic [CNT_W:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (flag) low_run <= '0;
    else if (low_run != {(CNT_W+1){1'b1}}) low_run <= low_run + 1'b1;
  end

  a_r7_write_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && flag) |=> (!flag && dsp_valid && dsp_data == $past(wbyte[CHAR_W-1:0])));
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && !dsp_ready) |=> (dsp_valid && $stable(dsp_data)));
  a_r9_min_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (low_run >= (CNT_W+1)'(MIN_BUSY)));
  a_r10_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && !flag) |=> $stable(dsp_data));
endmodule

// File: rtl/term_mmio.sv
module term_mmio
  import term_pkg::*;
#(
  parameter logic [31:0] BASE     = 32'hFFFF0000,
  parameter int          MIN_BUSY = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        kb_valid,
  input  logic [7:0]  kb_data,
  output logic        dsp_valid,
  output logic [7:0]  dsp_data,
  input  logic        dsp_ready,
  output logic        irq
);
  localparam int DATA_W = 32;

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic     hit, rd_in_dat, wr_in_ctl, wr_out_ctl, wr_out_dat;
  reg_sel_e which;

  term_decode #(.ADDR_W(32), .BASE(BASE)) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .hit(hit), .which(which), .rd_in_dat(rd_in_dat),
    .wr_in_ctl(wr_in_ctl), .wr_out_ctl(wr_out_ctl), .wr_out_dat(wr_out_dat)
  );

  logic              in_flag, in_en, out_flag, out_en;
  logic [CHAR_W-1:0] in_char;

  term_rx u_rx (
    .clk(clk), .rst_n(rst_int_n),
    .kb_valid(kb_valid), .kb_data(kb_data),
    .rd_dat(rd_in_dat), .wr_ctl(wr_in_ctl), .en_wbit(bus_wdata[EN_B]),
    .flag(in_flag), .en(in_en), .held(in_char)
  );

  term_tx #(.MIN_BUSY(MIN_BUSY)) u_tx (
    .clk(clk), .rst_n(rst_int_n),
    .wr_dat(wr_out_dat), .wbyte(bus_wdata[CHAR_W-1:0]),
    .wr_ctl(wr_out_ctl), .en_wbit(bus_wdata[EN_B]),
    .dsp_ready(dsp_ready),
    .flag(out_flag), .en(out_en),
    .dsp_valid(dsp_valid), .dsp_data(dsp_data)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit && !bus_we) begin
      unique case (which)
        SEL_IN_CTL:  begin bus_rdata[FLAG_B] = in_flag;  bus_rdata[EN_B] = in_en;  end
        SEL_IN_DAT:  bus_rdata[CHAR_W-1:0] = in_char;
        SEL_OUT_CTL: begin bus_rdata[FLAG_B] = out_flag; bus_rdata[EN_B] = out_en; end
        SEL_OUT_DAT: bus_rdata = '0;
      endcase
    end
    irq = (in_flag && in_en) || (out_flag && out_en);
  end

  a_r3_ctl_upper_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (hit && !bus_we && !which[0]) |-> (bus_rdata[DATA_W-1:2] == '0));
  a_r2_outside_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_sel && !hit) |-> (bus_rdata == '0));
  a_r11_irq_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!in_en && !out_en) |-> !irq);
endmodule

// File: tb/term_mmio_test.sv
module term_mmio_test;
  localparam logic [31:0] B = 32'hFFFF0000;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_sel, bus_we, kb_valid, dsp_ready;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [7:0] kb_data, dsp_data;
  logic dsp_valid, irq;

  int checks = 0, errors = 0, outs = 0;
  logic [7:0] last_out;

  always #2 clk = ~clk;

  term_mmio #(.BASE(B), .MIN_BUSY(NB)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kb_valid(kb_valid), .kb_data(kb_data), .dsp_valid(dsp_valid),
    .dsp_data(dsp_data), .dsp_ready(dsp_ready), .irq(irq)
  );

  always @(posedge clk) if (rst_n && dsp_valid && dsp_ready) begin
    last_out = dsp_data;
    outs = outs + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic kb(input logic [7:0] c);
    @(negedge clk);
    kb_valid = 1; kb_data = c;
    @(negedge clk);
    kb_valid = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk(!dsp_valid && !irq, "R1 outputs", {dsp_valid, irq}, 0);
    rd(B + 0, d);  chk(d == 0, "R1 in ctl", d, 0);
    rd(B + 8, d);  chk(d == 1, "R1 out ctl", d, 1);
  endtask

  task automatic t_rx;
    logic [31:0] d;
    kb(8'h41);
    rd(B + 0, d);  chk(d == 1, "R4 flag set", d, 1);
    kb(8'h42);
    rd(B + 0, d);  chk(d == 1, "R4 flag kept", d, 1);
    rd(B + 4, d);  chk(d == 32'h42, "R4 overwrite / R3 upper zero", d, 32'h42);
    rd(B + 0, d);  chk(d == 0, "R5 read clears", d, 0);
    rd(B + 12, d); chk(d == 0, "R3 out data reads zero", d, 0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    kb(8'h10);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = B + 4; kb_valid = 1; kb_data = 8'h77;
    @(negedge clk);
    bus_sel = 0; kb_valid = 0;
    rd(B + 0, d);  chk(d == 1, "R5 arrival wins flag", d, 1);
    rd(B + 4, d);  chk(d == 32'h77, "R5 arrival wins data", d, 32'h77);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(B + 0, 32'h3);
    rd(B + 0, d);  chk(d == 2, "R6 enable set, flag unchanged", d, 2);
    chk(!irq, "R11 no irq", irq, 0);
    kb(8'h33);
    chk(irq, "R11 input irq", irq, 1);
    rd(B + 4, d);
    chk(!irq, "R11 irq drops on read", irq, 0);
    wr(B + 0, 32'h0);
    wr(B + 8, 32'h2);
    chk(irq, "R11 output irq", irq, 1);
    wr(B + 8, 32'h0);
    chk(!irq, "R6 enable cleared", irq, 0);
  endtask

  task automatic t_tx_fast;
    logic [31:0] d;
    int lows;
    int o0;
    o0 = outs;
    wr(B + 12, 32'hABCD_EF5A);
    lows = 0;
    for (int i = 0; i < 20; i++) begin
      if (uut.bus_rdata == 0 && 0) lows = lows; // unused
      bus_sel = 1; bus_we = 0; bus_addr = B + 8;
      #1;
      if (bus_rdata[0]) break;
      lows++;
      @(negedge clk);
    end
    bus_sel = 0;
    chk(lows == NB, "R9 busy length", lows, NB);
    chk(outs == o0 + 1 && last_out == 8'h5A, "R7 byte sent", last_out, 8'h5A);
  endtask

  task automatic t_tx_stall;
    logic [31:0] d;
    dsp_ready = 0;
    wr(B + 12, 32'h61);
    chk(dsp_valid && dsp_data == 8'h61, "R7 byte offered", dsp_data, 8'h61);
    wr(B + 12, 32'h62);
    chk(dsp_data == 8'h61, "R10 ignored write", dsp_data, 8'h61);
    repeat (8) @(negedge clk);
    chk(dsp_valid && dsp_data == 8'h61, "R8 held during stall", dsp_data, 8'h61);
    rd(B + 8, d);  chk(d == 0, "R9 busy until accepted", d, 0);
    @(negedge clk); dsp_ready = 1;
    @(negedge clk);
    rd(B + 8, d);  chk(d == 1, "R9 ready after accept", d, 1);
    chk(last_out == 8'h61 && !dsp_valid, "R10 no second byte", last_out, 8'h61);
  endtask

  task automatic t_window;
    logic [31:0] d;
    int o0;
    o0 = outs;
    kb(8'h55);
    rd(32'hFFFE0004, d); chk(d == 0, "R2 outside read zero", d, 0);
    rd(B + 0, d);        chk(d == 1, "R2 outside read no side effect", d, 1);
    wr(32'h0000000C, 32'h99);
    repeat (2) @(negedge clk);
    chk(outs == o0 && !dsp_valid, "R2 outside write ignored", outs, o0);
    rd(B + 4, d);
  endtask

  initial begin
    bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    kb_valid = 0; kb_data = 0; dsp_ready = 1; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_rx();
    t_collide();
    t_irq();
    t_tx_fast();
    t_tx_stall();
    t_window();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule